// File: doc/BRIEF.md
# Buffered Five-Channel Down-Count Timer

This block is a timer peripheral with five independent down-counters behind a simple 32-bit register bus. Two shared 8-bit prescalers feed a power-of-two divider on each channel. Channels 0 and 1 use the first prescaler, and channels 2 to 4 use the second. The divider output is a one-cycle tick, and a running counter decrements by one on each tick.

Software never writes a counter directly. It fills a count buffer, and for channels 0 to 3 also a compare buffer. It then holds the channel's manual-update control bit, which copies the buffers into the working registers. Clearing manual update while start is set begins counting. When a running counter ticks at zero, it raises that channel's status flag. It then either reloads from its count buffer (periodic mode) or stops at zero (one-shot mode). Each channel has an interrupt line that is high while both its enable and its status bit are set. The live count can be read back; inverting it gives a rising timestamp. Channels 0 to 3 also drive a compare output.

Top module: `dct_timer`

## Requirements
- R1: After reset, every register reads zero, all interrupt lines are low and all compare outputs are low.
- R2: Register readback. The prescaler word at 0x00 keeps bits 15:0: the first prescaler is in bits 7:0 and the second in bits 15:8. The divider word at 0x04 keeps bits 19:0, with a 4-bit select per channel at bit 4×channel. Channel n's count buffer is at 0x0C+12n. Channels 0 to 3 have a compare buffer at 0x10+12n. Every buffer reads back what was written.
- R3: The control word at 0x08 packs one nibble per channel: channel 0 uses bits 3:0 and channel n (n≥1) uses bits 4n+7:4n+4, so bits 7:4 are unused and read zero. Within a nibble, start is bit 0, manual update is bit 1, invert is bit 2 and auto-reload is bit 3. Channel 4 instead has auto-reload at bit 22 and no invert bit, so control readback after writing all ones is 0x007FFF0F.
- R4: While manual update is set, the working counter takes the count buffer on every clock and does not count, even when start is set.
- R5: While start is set and manual update is clear, the counter decrements by one on each tick. With prescaler 0 and divider select 0, a tick occurs every clock.
- R6: A tick while the running count is zero sets the channel's status flag. With auto-reload set, the counter reloads from the count buffer, so the status flag repeats every (N+1) ticks for buffer value N.
- R7: Without auto-reload, after one underflow the counter holds at zero and sets no further status until the next manual update.
- R8: Clearing start freezes the counter at its current value.
- R9: A channel ticks once every (P+1)×2^S clocks. P is its prescaler field: prescaler 0 for channels 0 and 1, prescaler 1 for channels 2 to 4. S is its divider select, and any select above 4 acts as 4.
- R10: In the interrupt word at 0x44, bits 4:0 are the enables and bits 9:5 the status flags. Writing 1 to a status bit clears it and writing 0 leaves it. A new underflow in the same cycle wins over a clear. Interrupt line n is high exactly when enable n and status n are both set.
- R11: The live count of channel n (n≤3) reads at 0x14+12n, and that of channel 4 at 0x40.
- R12: For channels 0 to 3, the compare output is (working count < working compare) XOR invert bit. The working compare is loaded from the compare buffer by manual update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 5 | Per-channel interrupt lines |
| tout | output | 4 | Compare outputs of channels 0 to 3 |

## Verification
The hardest situations to reach are the timing relations that sit behind the prescaler and divider chain. These include the exact underflow period under a non-trivial prescale and divide, and the clamping of out-of-range divider selects. None of these timings can be read directly from a register. The stimulus puts a channel in periodic mode with interrupts enabled, then polls its interrupt line every cycle and clears the status at once. The cycle distance between two successive assertions is compared against (N+1)×(P+1)×2^S. The same method, run on channel 4 with its displaced auto-reload bit, shows that the irregular control packing really selects periodic behaviour.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int NCH       = 5;
  localparam int LAST_CH   = NCH - 1;
  localparam int SPLIT_CH  = 2;
  localparam int A_CFG0    = 'h00;
  localparam int A_CFG1    = 'h04;
  localparam int A_CTRL    = 'h08;
  localparam int A_INT     = 'h44;
  localparam int PRE1_LSB  = 8;

  // Control nibble used by a channel: a gap is left after channel 0.
  function automatic int ctrl_nib(input int ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

  function automatic int bit_start(input int ch);
    return 4 * ctrl_nib(ch);
  endfunction

  function automatic int bit_manual(input int ch);
    return 4 * ctrl_nib(ch) + 1;
  endfunction

  function automatic int bit_invert(input int ch);
    return 4 * ctrl_nib(ch) + 2;
  endfunction

  // Auto-reload shares the invert slot on the last channel.
  function automatic int bit_reload(input int ch);
    return 4 * ctrl_nib(ch) + ((ch == LAST_CH) ? 2 : 3);
  endfunction

  function automatic int cntb_addr(input int ch);
    return 'h0C + 12 * ch;
  endfunction

  function automatic int cmpb_addr(input int ch);
    return 'h10 + 12 * ch;
  endfunction

  function automatic int obs_addr(input int ch);
    return (ch == LAST_CH) ? 'h40 : 'h14 + 12 * ch;
  endfunction

  // Low-bit mask of the divider phase counter for a select value.
  function automatic logic [15:0] div_mask(input logic [3:0] sel, input int maxlog);
    int lg;
    lg = (int'(sel) > maxlog) ? maxlog : int'(sel);
    return 16'((1 << lg) - 1);
  endfunction

endpackage

// File: rtl/dct_prescale.sv
module dct_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pre,
  output logic          pulse
);

  logic [PW-1:0] pcnt_q;

  assign pulse = (pcnt_q >= pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (pulse) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  // A pulse is followed by a gap when the ratio exceeds one.
  p_pulse_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && pre != '0 && $stable(pre)) |=> !pulse);

endmodule

// File: rtl/dct_divider.sv
module dct_divider import dct_pkg::*; #(
  parameter int DSW    = 4,
  parameter int MAXLOG = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pulse_in,
  input  logic [DSW-1:0] sel,
  output logic           tick
);

  localparam int PHW = (MAXLOG < 1) ? 1 : MAXLOG;

  logic [PHW-1:0] phase_q;
  logic [PHW-1:0] mask;

  assign mask = PHW'(div_mask(4'(sel), MAXLOG));
  assign tick = pulse_in && ((phase_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (pulse_in) phase_q <= phase_q + 1'b1;
  end

  p_tick_needs_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_in && $stable(sel)) |=> $stable(phase_q));

endmodule

// File: rtl/dct_chan.sv
module dct_chan #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          manual,
  input  logic          reload,
  input  logic [CW-1:0] cnt_buf,
  output logic [CW-1:0] cnt,
  output logic          uflow
);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          step;

  assign step  = start && !manual && tick && !done_q;
  assign uflow = step && (cnt_q == '0);
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (manual) begin
      cnt_q  <= cnt_buf;
      done_q <= 1'b0;
    end else if (step) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (reload) cnt_q <= cnt_buf;
      else done_q <= 1'b1;
    end
  end

  p_manual_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (cnt == $past(cnt_buf)));

  p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1)));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && reload) |=> (cnt == $past(cnt_buf)));

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !reload) |=> (cnt == '0 && !uflow));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !manual) |=> $stable(cnt));

endmodule

// File: rtl/dct_timer.sv
module dct_timer import dct_pkg::*; #(
  parameter int AW     = 8,
  parameter int CW     = 32,
  parameter int PW     = 8,
  parameter int DSW    = 4,
  parameter int MAXLOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NCH-1:0]   irq,
  output logic [NCH-2:0]   tout
);

  localparam int NCMP = NCH - 1;

  logic [PW-1:0]  pre_q [2];
  logic [DSW-1:0] dsel_q [NCH];
  logic [NCH-1:0] start_q, manual_q, reload_q;
  logic [NCMP-1:0] inv_q;
  logic [CW-1:0]  cntb_q [NCH];
  logic [CW-1:0]  cmpb_q [NCMP];
  logic [CW-1:0]  cmpw_q [NCMP];
  logic [NCH-1:0] ien_q, ist_q;

  logic           wr_cfg0, wr_cfg1, wr_ctrl, wr_int;
  logic [NCH-1:0] wr_cntb;
  logic [NCMP-1:0] wr_cmpb;
  logic [1:0]     pulse;
  logic [NCH-1:0] tick, uflow;
  logic [CW-1:0]  cnt [NCH];

  assign wr_cfg0 = bus_wr && (bus_addr == AW'(A_CFG0));
  assign wr_cfg1 = bus_wr && (bus_addr == AW'(A_CFG1));
  assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
  assign wr_int  = bus_wr && (bus_addr == AW'(A_INT));

  // Prescalers
  for (genvar p = 0; p < 2; p++) begin : g_pre
    dct_prescale #(.PW(PW)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .pre   (pre_q[p]),
      .pulse (pulse[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q[0] <= '0;
      pre_q[1] <= '0;
    end else if (wr_cfg0) begin
      pre_q[0] <= bus_wdata[PW-1:0];
      pre_q[1] <= bus_wdata[PRE1_LSB +: PW];
    end
  end

  // Per-channel divider, counter and buffers
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign wr_cntb[ch] = bus_wr && (bus_addr == AW'(cntb_addr(ch)));

    dct_divider #(.DSW(DSW), .MAXLOG(MAXLOG)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_in (pulse[(ch < SPLIT_CH) ? 0 : 1]),
      .sel      (dsel_q[ch]),
      .tick     (tick[ch])
    );

    dct_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick[ch]),
      .start   (start_q[ch]),
      .manual  (manual_q[ch]),
      .reload  (reload_q[ch]),
      .cnt_buf (cntb_q[ch]),
      .cnt     (cnt[ch]),
      .uflow   (uflow[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dsel_q[ch]   <= '0;
        cntb_q[ch]   <= '0;
        start_q[ch]  <= 1'b0;
        manual_q[ch] <= 1'b0;
        reload_q[ch] <= 1'b0;
        ien_q[ch]    <= 1'b0;
        ist_q[ch]    <= 1'b0;
      end else begin
        if (wr_cfg1) dsel_q[ch] <= bus_wdata[4*ch +: DSW];
        if (wr_cntb[ch]) cntb_q[ch] <= bus_wdata[CW-1:0];
        if (wr_ctrl) begin
          start_q[ch]  <= bus_wdata[bit_start(ch)];
          manual_q[ch] <= bus_wdata[bit_manual(ch)];
          reload_q[ch] <= bus_wdata[bit_reload(ch)];
        end
        if (wr_int) ien_q[ch] <= bus_wdata[ch];
        if (uflow[ch]) ist_q[ch] <= 1'b1;
        else if (wr_int && bus_wdata[NCH + ch]) ist_q[ch] <= 1'b0;
      end
    end

    assign irq[ch] = ien_q[ch] && ist_q[ch];

    p_status_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ist_q[ch]) |-> $past(uflow[ch]));

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_int && bus_wdata[NCH + ch] && !uflow[ch]) |=> !ist_q[ch]);
  end

  // Compare path, channels without the last
  for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
    assign wr_cmpb[ch] = bus_wr && (bus_addr == AW'(cmpb_addr(ch)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmpb_q[ch] <= '0;
        cmpw_q[ch] <= '0;
        inv_q[ch]  <= 1'b0;
      end else begin
        if (wr_cmpb[ch]) cmpb_q[ch] <= bus_wdata[CW-1:0];
        if (wr_ctrl) inv_q[ch] <= bus_wdata[bit_invert(ch)];
        if (manual_q[ch]) cmpw_q[ch] <= cmpb_q[ch];
      end
    end

    assign tout[ch] = (cnt[ch] < cmpw_q[ch]) ^ inv_q[ch];
  end

  // Read decode
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_CFG0)) begin
      bus_rdata[PW-1:0]          = pre_q[0];
      bus_rdata[PRE1_LSB +: PW]  = pre_q[1];
    end
    if (bus_addr == AW'(A_CFG1)) begin
      for (int ch = 0; ch < NCH; ch++) bus_rdata[4*ch +: DSW] = dsel_q[ch];
    end
    if (bus_addr == AW'(A_CTRL)) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bus_rdata[bit_start(ch)]  = start_q[ch];
        bus_rdata[bit_manual(ch)] = manual_q[ch];
        bus_rdata[bit_reload(ch)] = reload_q[ch];
      end
      for (int ch = 0; ch < NCMP; ch++) bus_rdata[bit_invert(ch)] = inv_q[ch];
    end
    if (bus_addr == AW'(A_INT)) begin
      bus_rdata[NCH-1:0]     = ien_q;
      bus_rdata[2*NCH-1:NCH] = ist_q;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      if (bus_addr == AW'(cntb_addr(ch))) bus_rdata[CW-1:0] = cntb_q[ch];
      if (bus_addr == AW'(obs_addr(ch)))  bus_rdata[CW-1:0] = cnt[ch];
    end
    for (int ch = 0; ch < NCMP; ch++) begin
      if (bus_addr == AW'(cmpb_addr(ch))) bus_rdata[CW-1:0] = cmpb_q[ch];
    end
  end

endmodule

// File: tb/dct_timer_tb.sv
module dct_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  irq;
  logic [3:0]  tout;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dct_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tout(tout)
  );

  // {write, addr, data, expected}
  localparam int NV = 23;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h1234ABCD, 32'h0},
    {1'b0, 8'h00, 32'h0,        32'h0000ABCD},
    {1'b1, 8'h04, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h04, 32'h0,        32'h000FFFFF},
    {1'b1, 8'h04, 32'h0,        32'h0},
    {1'b1, 8'h0C, 32'h11,       32'h0},
    {1'b0, 8'h0C, 32'h0,        32'h11},
    {1'b1, 8'h10, 32'h22,       32'h0},
    {1'b0, 8'h10, 32'h0,        32'h22},
    {1'b1, 8'h30, 32'h33,       32'h0},
    {1'b0, 8'h30, 32'h0,        32'h33},
    {1'b1, 8'h34, 32'h44,       32'h0},
    {1'b0, 8'h34, 32'h0,        32'h44},
    {1'b1, 8'h3C, 32'h55,       32'h0},
    {1'b0, 8'h3C, 32'h0,        32'h55},
    {1'b1, 8'h08, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h08, 32'h0,        32'h007FFF0F},
    {1'b1, 8'h08, 32'h0,        32'h0},
    {1'b0, 8'h08, 32'h0,        32'h0},
    {1'b0, 8'h14, 32'h0,        32'h11},
    {1'b0, 8'h38, 32'h0,        32'h33},
    {1'b0, 8'h40, 32'h0,        32'h55},
    {1'b1, 8'h00, 32'h0,        32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  // Clocks between two successive interrupt assertions of a channel.
  task automatic measure(input int ch, output int per);
    int t0;
    bit first;
    per = -1; first = 1'b1; t0 = 0;
    wr(8'h44, 32'h3FF);
    for (int i = 0; i < 600; i++) begin
      if (irq[ch]) begin
        if (first) begin
          t0 = cyc; first = 1'b0;
          wr(8'h44, 32'h3FF);
        end else begin
          per = cyc - t0;
          break;
        end
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1 cfg0");
    rd_chk(8'h08, 32'h0, "R1 ctrl");
    rd_chk(8'h44, 32'h0, "R1 int");
    rd_chk(8'h14, 32'h0, "R1 count");
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 tout", 32'(tout), 32'h0);

    // Table: R2 readback, R3 packing, R11 observation, R4 load
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rd_chk(VEC[i][71:64], VEC[i][31:0], $sformatf("R2/R3/R11 vector %0d", i));
    end

    // R5 decrement per clock, R8 freeze
    wr(8'h0C, 32'd10);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h1);
    repeat (3) @(negedge clk);
    wr(8'h08, 32'h0);
    rd_chk(8'h14, 32'd6, "R5 four ticks");
    repeat (5) @(negedge clk);
    rd_chk(8'h14, 32'd6, "R8 frozen");

    // R4 manual update overrides start
    wr(8'h08, 32'h3);
    repeat (5) @(negedge clk);
    rd_chk(8'h14, 32'd10, "R4 held at buffer");
    wr(8'h08, 32'h0);

    // R6 periodic underflow
    wr(8'h44, 32'h1F);
    wr(8'h0C, 32'd7);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    measure(0, per);
    check("R6 period", 32'(per), 32'd8);
    wr(8'h08, 32'h0);

    // R9 prescale and divide
    wr(8'h00, 32'h0002);
    wr(8'h04, 32'h1);
    wr(8'h0C, 32'd3);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    measure(0, per);
    check("R9 prescale 3 divide 2", 32'(per), 32'd24);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h7);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h9);
    measure(0, per);
    check("R9 select clamp", 32'(per), 32'd16);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0005);
    wr(8'h24, 32'd7);
    wr(8'h08, 32'h2000);
    wr(8'h08, 32'h9000);
    measure(2, per);
    check("R9 second prescaler", 32'(per), 32'd8);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);

    // R3 channel 4 reload at bit 22
    wr(8'h3C, 32'd4);
    wr(8'h08, 32'h200000);
    wr(8'h08, 32'h500000);
    measure(4, per);
    check("R3 channel 4 periodic", 32'(per), 32'd5);
    wr(8'h08, 32'h0);

    // R7 one-shot
    wr(8'h44, 32'h3FF);
    wr(8'h18, 32'd2);
    wr(8'h08, 32'h200);
    wr(8'h08, 32'h100);
    repeat (10) @(negedge clk);
    rd_chk(8'h44, 32'h05F, "R7 single status");
    wr(8'h44, 32'h3FF);
    repeat (10) @(negedge clk);
    rd_chk(8'h44, 32'h01F, "R7 no repeat");
    rd_chk(8'h20, 32'h0, "R7 held at zero");

    // R10 enable masking and write-one-to-clear
    wr(8'h44, 32'h3E0);
    wr(8'h08, 32'h200);
    wr(8'h08, 32'h100);
    repeat (10) @(negedge clk);
    check("R10 masked irq", 32'(irq), 32'h0);
    rd_chk(8'h44, 32'h040, "R10 status only");
    wr(8'h44, 32'h002);
    rd_chk(8'h44, 32'h042, "R10 zero keeps status");
    check("R10 irq raised", 32'(irq), 32'h2);
    wr(8'h44, 32'h042);
    rd_chk(8'h44, 32'h002, "R10 cleared");
    check("R10 irq dropped", 32'(irq), 32'h0);

    // R12 compare output
    wr(8'h18, 32'd5);
    wr(8'h1C, 32'd3);
    wr(8'h08, 32'h200);
    @(negedge clk);
    check("R12 above compare", 32'(tout[1]), 32'h0);
    wr(8'h08, 32'h600);
    @(negedge clk);
    check("R12 inverted", 32'(tout[1]), 32'h1);
    wr(8'h1C, 32'd9);
    @(negedge clk);
    @(negedge clk);
    check("R12 below compare inverted", 32'(tout[1]), 32'h0);
    wr(8'h08, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule